// File: doc/BRIEF.md
# RV32I Integer ALU

This block is the arithmetic and logic unit of a 32-bit base-integer RISC-V core. It is purely combinational. It takes two operands and a four-bit operation code and returns one 32-bit result in the same time step, with no clock and no state. The decode stage builds the operation code by placing bit 5 of funct7 above the three funct3 bits, so register and immediate forms of the base arithmetic, logic, shift and compare instructions share one path.

The ten functions are add, subtract, shift left, signed and unsigned set-less-than, exclusive-or, logical and arithmetic shift right, inclusive-or and and. Subtraction and both compares share one adder, which adds the inverted second operand plus one. Shifts take their distance from the low five bits of the second operand. Arithmetic wraps modulo 2^32 and sets no flag. The block sits between operand selection and writeback. It has no data stream, so it has no valid/ready handshake: a result follows its inputs directly.

Top module: `rv_int_alu`

## Requirements
- R1: Code 4'b0000 (add) gives (A + B) mod 2^32, with no overflow indication.
- R2: Code 4'b1000 (subtract) gives (A - B) mod 2^32.
- R3: Code 4'b0001 (shift left) gives A shifted left by the shift distance, with zeros in the vacated low bits.
- R4: Code 4'b0010 (signed set-less-than) gives 32'd1 when A < B as two's-complement values, otherwise 32'd0. Bits 31:1 are always zero.
- R5: Code 4'b0011 (unsigned set-less-than) gives 32'd1 when A < B as unsigned values, otherwise 32'd0. Bits 31:1 are always zero.
- R6: Code 4'b0100 gives A XOR B, code 4'b0110 gives A OR B, and code 4'b0111 gives A AND B.
- R7: Code 4'b0101 (logical shift right) gives A shifted right by the shift distance, with zeros in the vacated high bits.
- R8: Code 4'b1101 (arithmetic shift right) gives A shifted right by the shift distance, with A[31] copied into the vacated high bits.
- R9: The shift distance is B[4:0]. Bits 31:5 of B have no effect on any shift result.
- R10: Each of the six codes not listed above (4'b1001, 4'b1010, 4'b1011, 4'b1100, 4'b1110, 4'b1111) gives 32'd0.
- R11: The result depends only on the current inputs and follows a change of any input without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code {funct7[5], funct3} |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand; bits 4:0 give the shift distance |
| result | output | 32 | Result of the selected operation |

## Verification
Every result is due zero cycles after its stimulus, because no register lies between any input and the result. The bench changes the inputs just after a falling clock edge and samples the result 2 ns later, well before the next rising edge. No check can then depend on clock alignment, and each sample shows only the inputs just applied. One directed check changes the operands in the middle of a clock phase to show that the result follows them with no edge at all.

// File: rtl/rv_alu_pkg.sv
package rv_alu_pkg;

  localparam int unsigned SEL_W = 4;

  // Operation codes: {funct7[5], funct3}
  typedef enum logic [SEL_W-1:0] {
    OP_ADD  = 4'b0000,
    OP_SLL  = 4'b0001,
    OP_SLT  = 4'b0010,
    OP_SLTU = 4'b0011,
    OP_XOR  = 4'b0100,
    OP_SRL  = 4'b0101,
    OP_OR   = 4'b0110,
    OP_AND  = 4'b0111,
    OP_SUB  = 4'b1000,
    OP_SRA  = 4'b1101
  } alu_op_e;

  // Selector for the bitwise unit (low two funct3 bits)
  typedef enum logic [1:0] {
    BW_XOR  = 2'b00,
    BW_NONE = 2'b01,
    BW_OR   = 2'b10,
    BW_AND  = 2'b11
  } bw_sel_e;

endpackage

// File: rtl/alu_addsub.sv
// Shared adder: add, or subtract by adding the inverted operand plus one.
// The compare outputs come from the same adder and are valid only while sub_en is high.
module alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub_en,
  output logic [W-1:0] sum,
  output logic         lt_signed,
  output logic         lt_unsigned
);

  localparam int unsigned MSB = W - 1;

  logic [W-1:0] b_eff;
  logic [W:0]   wide;
  logic         carry;

  always_comb begin
    b_eff = sub_en ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub_en};
  end

  assign sum   = wide[W-1:0];
  assign carry = wide[W];

  // When subtracting, no carry out means a borrow, so a < b unsigned
  assign lt_unsigned = ~carry;

  // Signs differ: a is the smaller one when it is negative.
  // Signs match: the difference cannot overflow, so its sign decides.
  assign lt_signed = (a[MSB] != b[MSB]) ? a[MSB] : sum[MSB];

endmodule

// File: rtl/alu_shifter.sv
// Log-depth barrel shifter. A right shift is the only core operation.
// A left shift reverses the bits before and after it.
module alu_shifter #(
  parameter int unsigned W  = 32,
  parameter int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  data,
  input  logic [SW-1:0] amt,
  input  logic          go_left,
  input  logic          arith,
  output logic [W-1:0]  shifted
);

  localparam int unsigned MSB = W - 1;

  logic [W-1:0] rev_in;
  logic [W-1:0] rev_out;
  logic [W-1:0] stage [0:SW];
  logic         fill;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      rev_in[i] = data[MSB - i];
    end
  end

  assign fill     = arith & ~go_left & data[MSB];
  assign stage[0] = go_left ? rev_in : data;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int unsigned DIST = 1 << k;
    assign stage[k+1] = amt[k] ? {{DIST{fill}}, stage[k][W-1:DIST]} : stage[k];
  end

  always_comb begin
    for (int i = 0; i < W; i++) begin
      rev_out[i] = stage[SW][MSB - i];
    end
  end

  assign shifted = go_left ? rev_out : stage[SW];

endmodule

// File: rtl/alu_bitwise.sv
// Bitwise unit: xor / or / and
module alu_bitwise #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]          a,
  input  logic [W-1:0]          b,
  input  rv_alu_pkg::bw_sel_e   sel,
  output logic [W-1:0]          y
);

  import rv_alu_pkg::*;

  always_comb begin
    case (sel)
      BW_XOR:  y = a ^ b;
      BW_OR:   y = a | b;
      BW_AND:  y = a & b;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/rv_int_alu.sv
module rv_int_alu #(
  parameter int unsigned XLEN = 32
) (
  input  logic [3:0]      op_sel,
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  output logic [XLEN-1:0] result
);

  import rv_alu_pkg::*;

  localparam int unsigned SHW = $clog2(XLEN);

  logic            sub_en;
  logic [XLEN-1:0] sum;
  logic            lt_s;
  logic            lt_u;
  logic            go_left;
  logic            arith;
  logic [XLEN-1:0] shifted;
  logic [XLEN-1:0] bw_y;
  bw_sel_e         bw_sel;

  assign sub_en  = (op_sel == OP_SUB) || (op_sel == OP_SLT) || (op_sel == OP_SLTU);
  assign go_left = (op_sel == OP_SLL);
  assign arith   = (op_sel == OP_SRA);
  assign bw_sel  = bw_sel_e'(op_sel[1:0]);

  alu_addsub #(.W(XLEN)) u_addsub (
    .a           (opnd_a),
    .b           (opnd_b),
    .sub_en      (sub_en),
    .sum         (sum),
    .lt_signed   (lt_s),
    .lt_unsigned (lt_u)
  );

  alu_shifter #(.W(XLEN), .SW(SHW)) u_shift (
    .data    (opnd_a),
    .amt     (opnd_b[SHW-1:0]),
    .go_left (go_left),
    .arith   (arith),
    .shifted (shifted)
  );

  alu_bitwise #(.W(XLEN)) u_bitwise (
    .a   (opnd_a),
    .b   (opnd_b),
    .sel (bw_sel),
    .y   (bw_y)
  );

  always_comb begin
    case (op_sel)
      OP_ADD, OP_SUB:          result = sum;
      OP_SLT:                  result = {{(XLEN-1){1'b0}}, lt_s};
      OP_SLTU:                 result = {{(XLEN-1){1'b0}}, lt_u};
      OP_SLL, OP_SRL, OP_SRA:  result = shifted;
      OP_XOR, OP_OR, OP_AND:   result = bw_y;
      default:                 result = '0;
    endcase
  end

endmodule

// File: rtl/rv_int_alu_chk.sv
module rv_int_alu_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic [3:0]      op_sel,
  input logic [XLEN-1:0] opnd_a,
  input logic [XLEN-1:0] opnd_b,
  input logic [XLEN-1:0] result
);

  import rv_alu_pkg::*;

  localparam int unsigned SHW = $clog2(XLEN);

  logic known;
  assign known = !$isunknown({op_sel, opnd_a, opnd_b, result});

  always_comb begin
    if (known) begin
      if (op_sel == OP_ADD) begin
        // R1
        add_wrap_chk: assert (result - opnd_b == opnd_a)
          else $error("add result inconsistent");
      end
      if (op_sel == OP_SUB) begin
        // R2
        sub_wrap_chk: assert (result + opnd_b == opnd_a)
          else $error("sub result inconsistent");
      end
      if (op_sel == OP_SLL && opnd_b[SHW-1:0] != '0) begin
        // R3
        sll_zero_fill_chk: assert (result[0] == 1'b0)
          else $error("sll low bit not zero");
      end
      if (op_sel == OP_SLT) begin
        // R4
        slt_upper_chk: assert (result[XLEN-1:1] == '0)
          else $error("slt upper bits set");
      end
      if (op_sel == OP_SLTU) begin
        // R5
        sltu_upper_chk: assert (result[XLEN-1:1] == '0)
          else $error("sltu upper bits set");
      end
      if (op_sel == OP_XOR) begin
        // R6
        xor_undo_chk: assert ((result ^ opnd_b) == opnd_a)
          else $error("xor result inconsistent");
      end
      if (op_sel == OP_SRL && opnd_b[SHW-1:0] != '0) begin
        // R7
        srl_zero_fill_chk: assert (result[XLEN-1] == 1'b0)
          else $error("srl top bit not zero");
      end
      if (op_sel == OP_SRA) begin
        // R8
        sra_sign_keep_chk: assert (result[XLEN-1] == opnd_a[XLEN-1])
          else $error("sra sign not kept");
      end
      if (!(op_sel inside {OP_ADD, OP_SUB, OP_SLL, OP_SLT, OP_SLTU,
                           OP_XOR, OP_SRL, OP_SRA, OP_OR, OP_AND})) begin
        // R10
        unused_zero_chk: assert (result == '0)
          else $error("unused code gave nonzero result");
      end
    end
  end

endmodule

bind rv_int_alu rv_int_alu_chk #(.XLEN(XLEN)) u_chk (
  .op_sel (op_sel),
  .opnd_a (opnd_a),
  .opnd_b (opnd_b),
  .result (result)
);

// File: tb/rv_int_alu_bench.sv
`timescale 1ns/1ps
module rv_int_alu_bench;

  logic        clk = 1'b0;
  logic [3:0]  op_sel = 4'd0;
  logic [31:0] opnd_a = 32'd0;
  logic [31:0] opnd_b = 32'd0;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  rv_int_alu u_rv_int_alu (
    .op_sel (op_sel),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .result (result)
  );

  function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a,
                                        input logic [31:0] b);
    logic [4:0] sh;
    sh = b[4:0];
    case (op)
      4'b0000: return a + b;
      4'b1000: return a - b;
      4'b0001: return a << sh;
      4'b0010: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'b0011: return (a < b) ? 32'd1 : 32'd0;
      4'b0100: return a ^ b;
      4'b0101: return a >> sh;
      4'b1101: return 32'($signed(a) >>> sh);
      4'b0110: return a | b;
      4'b0111: return a & b;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'b0000: return "R1";
      4'b1000: return "R2";
      4'b0001: return "R3";
      4'b0010: return "R4";
      4'b0011: return "R5";
      4'b0100, 4'b0110, 4'b0111: return "R6";
      4'b0101: return "R7";
      4'b1101: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] exp);
    checks++;
    if (result !== exp) begin
      errors++;
      $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h",
               tag, op_sel, opnd_a, opnd_b, result, exp);
    end
  endtask

  // Drive after the falling edge, sample 2 ns later
  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_sel = op;
    opnd_a = a;
    opnd_b = b;
    #2;
    check(tag_of(op), model(op, a, b));
  endtask

  function automatic logic [31:0] pick_val();
    case ($urandom_range(0, 7))
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'h7FFF_FFFF;
      4: return 32'h0000_0001;
      default: return $urandom();
    endcase
  endfunction

  initial begin
    logic [3:0] ops [10];
    ops = '{4'b0000, 4'b1000, 4'b0001, 4'b0010, 4'b0011,
            4'b0100, 4'b0101, 4'b1101, 4'b0110, 4'b0111};
    void'($urandom(32'd20240611));

    // Idle state: all-zero inputs give zero
    #3;
    check("R1", 32'd0);

    // R1 / R2 wrap corners
    apply(4'b0000, 32'hFFFF_FFFF, 32'h0000_0001);
    check("R1", 32'h0000_0000);
    apply(4'b0000, 32'h7FFF_FFFF, 32'h0000_0001);
    check("R1", 32'h8000_0000);
    apply(4'b1000, 32'h0000_0000, 32'h0000_0001);
    check("R2", 32'hFFFF_FFFF);
    apply(4'b1000, 32'h8000_0000, 32'h0000_0001);
    check("R2", 32'h7FFF_FFFF);

    // R4 / R5 sign-sensitive compares
    apply(4'b0010, 32'h8000_0000, 32'h0000_0001);
    check("R4", 32'd1);
    apply(4'b0011, 32'h8000_0000, 32'h0000_0001);
    check("R5", 32'd0);
    apply(4'b0010, 32'h7FFF_FFFF, 32'h8000_0000);
    check("R4", 32'd0);
    apply(4'b0011, 32'hFFFF_FFFE, 32'hFFFF_FFFF);
    check("R5", 32'd1);
    apply(4'b0010, 32'h1234_5678, 32'h1234_5678);
    check("R4", 32'd0);

    // R3 / R7 / R8 shift extremes
    apply(4'b0001, 32'h8000_0001, 32'd31);
    check("R3", 32'h8000_0000);
    apply(4'b0101, 32'h8000_0000, 32'd31);
    check("R7", 32'h0000_0001);
    apply(4'b1101, 32'h8000_0000, 32'd31);
    check("R8", 32'hFFFF_FFFF);
    apply(4'b1101, 32'h4000_0000, 32'd30);
    check("R8", 32'h0000_0001);
    apply(4'b1101, 32'hF0F0_0000, 32'd0);
    check("R8", 32'hF0F0_0000);

    // R9: upper bits of B ignored for shifts
    apply(4'b0001, 32'h0000_00FF, 32'hFFFF_FFE4);
    check("R9", 32'h0000_0FF0);
    apply(4'b0101, 32'hFF00_0000, 32'h8000_0028);
    check("R9", 32'h00FF_0000);
    apply(4'b1101, 32'h8000_0000, 32'h0000_0020);
    check("R9", 32'h8000_0000);

    // R6 bitwise
    apply(4'b0100, 32'hF0F0_F0F0, 32'hFF00_FF00);
    check("R6", 32'h0FF0_0FF0);
    apply(4'b0110, 32'hF0F0_F0F0, 32'h0F00_000F);
    check("R6", 32'hFFF0_F0FF);
    apply(4'b0111, 32'hF0F0_F0F0, 32'hFF00_FF00);
    check("R6", 32'hF000_F000);

    // R10: every unused code with all-ones operands
    for (int c = 0; c < 16; c++) begin
      if (c == 9 || c == 10 || c == 11 || c == 12 || c == 14 || c == 15) begin
        apply(4'(c), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        check("R10", 32'd0);
      end
    end

    // R11: inputs change mid-phase, no clock edge between change and sample
    @(posedge clk);
    #3;
    op_sel = 4'b0000;
    opnd_a = 32'd100;
    opnd_b = 32'd23;
    #1;
    check("R11", 32'd123);
    opnd_b = 32'd900;
    #1;
    check("R11", 32'd1000);

    // Random: every listed op over mixed operands
    for (int n = 0; n < 3000; n++) begin
      apply(ops[$urandom_range(0, 9)], pick_val(), pick_val());
    end
    // Random: any 4-bit code including unused ones
    for (int n = 0; n < 800; n++) begin
      apply(4'($urandom_range(0, 15)), pick_val(), pick_val());
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule